// File: doc/BRIEF.md
# USB Device Endpoint FIFO Bank

This block buffers endpoint payload bytes between a processor register bus and a USB device protocol core. Every endpoint owns two byte-wide FIFOs. The processor fills one with bytes for IN transfers and empties the other of bytes received on OUT transfers. Per-endpoint level flags (room to write, data to read) and packet-done flags serve as interrupt lines that pace the software.

On the core side, one endpoint number and one direction bit pick the active FIFO. The head of the chosen transmit FIFO is presented on a single outgoing data bus, and a single incoming data bus feeds the chosen receive FIFO. The core may draw transmit bytes only after software has committed the packet. The core ends a received packet with an end-of-packet strobe.

The eight payload bytes of a control SETUP stage never enter a FIFO. They are captured into a dedicated register set. The first byte of a new SETUP stage flushes both FIFOs of endpoint 0 and withdraws the previous setup-valid indication.

Top module: `usbep_fifo_bank`

## Requirements
- R1: After synchronous active-low reset, every FIFO is empty. All bits of `tx_req` read 1. All bits of `rx_req`, `tx_done`, `rx_done`, `tx_err`, `rx_err` and `setup_valid` read 0.
- R2: A transmit FIFO holds `DEPTH` (8) bytes. Its `tx_req` bit is 1 exactly while fewer than 8 bytes are stored. A CPU write to a full transmit FIFO is discarded and sets that endpoint's `tx_err` bit, which stays set until reset.
- R3: `cpu_commit` sets `tx_done` for endpoint `cpu_wr_ep` only if that FIFO holds data after the cycle; a commit to an empty FIFO is ignored. `core_tx_valid` is 0 for an uncommitted endpoint even when bytes are stored.
- R4: With `core_dir`=1 (IN) and a committed endpoint selected, each `core_tx_rd` pulse pops one byte. Bytes leave in write order on `core_tx_data`. `tx_done` clears when the last stored byte is popped.
- R5: With `core_dir`=0 (OUT), `core_rx_wr` stores `core_rx_data` into the selected endpoint's receive FIFO. `rx_req` is 1 while that FIFO is not empty. `core_rx_ready` is 0 while the selected receive FIFO holds 8 bytes, and a core write then is discarded.
- R6: `cpu_rd_data` shows the oldest byte of receive FIFO `cpu_rd_ep`, and `cpu_rd_en` pops it. A read of an empty receive FIFO changes no data and sets that endpoint's sticky `rx_err` bit.
- R7: `core_rx_eop` (with `core_dir`=0) sets `rx_done` of the selected endpoint if its FIFO then holds bytes, and marks all those bytes as the packet. `rx_done` clears when the CPU reads the last marked byte. An end-of-packet on an empty FIFO is ignored.
- R8: Bytes strobed by `setup_wr` fill the setup registers in order. Byte 0 lands in `setup_packet[7:0]` and byte 7 in `setup_packet[63:56]`. `setup_valid` rises after the eighth byte. No setup byte enters any endpoint FIFO.
- R9: The first byte of each SETUP stage clears `setup_valid` and empties both FIFOs of endpoint 0, clearing their done flags. Other endpoints are not touched.
- R10: Operations on one endpoint leave the FIFOs and flags of all other endpoints unchanged.
- R11: `core_tx_rd` has no effect while `core_dir`=0, and `core_rx_wr`/`core_rx_eop` have no effect while `core_dir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe into a transmit FIFO |
| cpu_wr_ep | input | 3 | Endpoint for CPU write and commit |
| cpu_wr_data | input | 8 | CPU write byte |
| cpu_commit | input | 1 | Marks the transmit packet of `cpu_wr_ep` complete |
| cpu_rd_en | input | 1 | CPU read strobe from a receive FIFO |
| cpu_rd_ep | input | 3 | Endpoint for CPU read |
| cpu_rd_data | output | 8 | Oldest byte of the addressed receive FIFO |
| tx_req | output | 8 | Per-endpoint transmit FIFO has room |
| tx_done | output | 8 | Per-endpoint transmit packet committed and pending |
| tx_err | output | 8 | Per-endpoint sticky write-overflow error |
| rx_req | output | 8 | Per-endpoint receive FIFO has a byte |
| rx_done | output | 8 | Per-endpoint received packet awaiting CPU drain |
| rx_err | output | 8 | Per-endpoint sticky read-underflow error |
| core_ep | input | 3 | Active endpoint on the core side |
| core_dir | input | 1 | Active direction: 1 IN (transmit), 0 OUT (receive) |
| core_tx_rd | input | 1 | Core pops one transmit byte |
| core_tx_data | output | 8 | Head byte of the active transmit FIFO |
| core_tx_valid | output | 1 | Active transmit FIFO is committed and holds a byte |
| core_rx_wr | input | 1 | Core pushes one receive byte |
| core_rx_data | input | 8 | Receive byte from the core |
| core_rx_eop | input | 1 | End of received packet |
| core_rx_ready | output | 1 | Active receive FIFO has room |
| setup_wr | input | 1 | SETUP payload byte strobe |
| setup_data | input | 8 | SETUP payload byte |
| setup_packet | output | 64 | Captured SETUP payload, byte 0 lowest |
| setup_valid | output | 1 | Eight SETUP bytes captured |

## Verification
The transmit path runs in three patterns. A straight fill of 8 bytes followed by a full drain exposes depth, overflow and ordering errors. Writes added after the commit and interleaved with pops show whether the done flag tracks the real occupancy. Pops attempted with the wrong direction show whether direction gating holds. The receive path is tried with an end-of-packet marked separately after a full FIFO, with an end-of-packet together with the last byte, and with an end-of-packet on an empty FIFO; these separate the packet-length latch from the simple empty test. Two back-to-back SETUP stages, sent while endpoint 0 holds data in both directions, show whether the flush reaches only endpoint 0 and whether the valid flag is re-armed.

// File: rtl/usbep_pkg.sv
// Package: shared types for the endpoint FIFO bank.
// Assumes: byte-wide payload on both CPU and core sides.
package usbep_pkg;
    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } ep_dir_e;
endpackage

// File: rtl/usbep_byte_fifo.sv
// Module: synchronous show-ahead FIFO with flush.
// Assumes: push to full and pop from empty are filtered here as well as by
// the caller; flush has priority over push and pop in the same cycle.
module usbep_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    // Store the pushed byte; storage is not reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/usbep_tx_lane.sv
// Module: one endpoint's transmit path: FIFO, commit flag, overflow error.
// Assumes: the core may pop only while the packet is committed; the commit
// flag drops once the FIFO runs empty.
module usbep_tx_lane #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_commit,
    input  logic          core_pop,
    output logic          req,
    output logic          done,
    output logic          err,
    output logic          avail,
    output logic [DW-1:0] head
);
    logic [CW-1:0] count;
    logic          full;
    logic          empty;
    logic          push_ok;
    logic          pop_ok;
    logic [CW:0]   cnt_after;

    assign push_ok   = cpu_wr && !full;
    assign pop_ok    = core_pop && done && !empty;
    assign cnt_after = {1'b0, count} + (CW+1)'(push_ok) - (CW+1)'(pop_ok);
    assign req       = !full;
    assign avail     = done && !empty;

    usbep_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push_ok),
        .push_data (cpu_data),
        .pop       (pop_ok),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    // Commit flag: set by a commit with data present, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) done <= 1'b0;
        else                 done <= (done || cpu_commit) && (cnt_after != '0);
    end

    // Sticky overflow error.
    always_ff @(posedge clk) begin
        if (!rst_n)              err <= 1'b0;
        else if (cpu_wr && full) err <= 1'b1;
    end
endmodule

// File: rtl/usbep_rx_lane.sv
// Module: one endpoint's receive path: FIFO, packet-done flag with a
// pending-byte count, underflow error.
// Assumes: an end-of-packet marks every byte held at that moment as part of
// the packet to be drained by the CPU.
module usbep_rx_lane #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          core_wr,
    input  logic [DW-1:0] core_data,
    input  logic          core_eop,
    input  logic          cpu_rd,
    output logic          req,
    output logic          ready,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] head
);
    logic [CW-1:0] count;
    logic [CW-1:0] pend;
    logic          full;
    logic          empty;
    logic          push_ok;
    logic          pop_ok;
    logic [CW:0]   cnt_after;

    assign push_ok   = core_wr && !full;
    assign pop_ok    = cpu_rd && !empty;
    assign cnt_after = {1'b0, count} + (CW+1)'(push_ok) - (CW+1)'(pop_ok);
    assign req       = !empty;
    assign ready     = !full;

    usbep_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push_ok),
        .push_data (core_data),
        .pop       (pop_ok),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    // Packet-done flag and the number of marked bytes still unread.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            done <= 1'b0;
            pend <= '0;
        end else if (core_eop && cnt_after != '0) begin
            done <= 1'b1;
            pend <= cnt_after[CW-1:0];
        end else if (pop_ok && done) begin
            if (pend == CW'(1)) begin
                done <= 1'b0;
                pend <= '0;
            end else begin
                pend <= pend - CW'(1);
            end
        end
    end

    // Sticky underflow error.
    always_ff @(posedge clk) begin
        if (!rst_n)              err <= 1'b0;
        else if (cpu_rd && empty) err <= 1'b1;
    end
endmodule

// File: rtl/usbep_setup_regs.sv
// Module: capture registers for the SETUP payload of a control transfer.
// Assumes: a SETUP stage delivers exactly NBYTES strobes; the strobe that
// finds the byte index at zero opens a new stage.
module usbep_setup_regs #(
    parameter int DW     = 8,
    parameter int NBYTES = 8,
    localparam int IW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [DW-1:0]        data,
    output logic [NBYTES*DW-1:0] packet,
    output logic                 valid,
    output logic                 start
);
    logic [DW-1:0] bytes_q [NBYTES];
    logic [IW-1:0] idx;

    assign start = wr && (idx == '0);

    // Flatten the captured bytes, byte 0 in the lowest lane.
    always_comb begin
        for (int i = 0; i < NBYTES; i++) packet[i*DW +: DW] = bytes_q[i];
    end

    // Byte storage and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
        end else if (wr) begin
            bytes_q[idx] <= data;
            idx <= (idx == IW'(NBYTES - 1)) ? '0 : idx + IW'(1);
        end
    end

    // Valid flag: dropped at stage start, raised by the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  valid <= 1'b0;
        else if (wr && idx == IW'(NBYTES - 1))       valid <= 1'b1;
        else if (start)                              valid <= 1'b0;
    end
endmodule

// File: rtl/usbep_fifo_bank.sv
// Module: top of the endpoint FIFO bank. Instantiates one transmit and one
// receive lane per endpoint plus the SETUP capture registers, and steers the
// active endpoint onto the core-side buses.
// Assumes: NUM_EP is a power of two so every endpoint code is valid.
module usbep_fifo_bank
    import usbep_pkg::*;
#(
    parameter int NUM_EP      = 8,
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter int SETUP_BYTES = 8,
    localparam int EPW        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_wr_en,
    input  logic [EPW-1:0]            cpu_wr_ep,
    input  logic [DW-1:0]             cpu_wr_data,
    input  logic                      cpu_commit,
    input  logic                      cpu_rd_en,
    input  logic [EPW-1:0]            cpu_rd_ep,
    output logic [DW-1:0]             cpu_rd_data,
    output logic [NUM_EP-1:0]         tx_req,
    output logic [NUM_EP-1:0]         tx_done,
    output logic [NUM_EP-1:0]         tx_err,
    output logic [NUM_EP-1:0]         rx_req,
    output logic [NUM_EP-1:0]         rx_done,
    output logic [NUM_EP-1:0]         rx_err,
    input  logic [EPW-1:0]            core_ep,
    input  logic                      core_dir,
    input  logic                      core_tx_rd,
    output logic [DW-1:0]             core_tx_data,
    output logic                      core_tx_valid,
    input  logic                      core_rx_wr,
    input  logic [DW-1:0]             core_rx_data,
    input  logic                      core_rx_eop,
    output logic                      core_rx_ready,
    input  logic                      setup_wr,
    input  logic [DW-1:0]             setup_data,
    output logic [SETUP_BYTES*DW-1:0] setup_packet,
    output logic                      setup_valid
);
    logic [DW-1:0]     tx_head [NUM_EP];
    logic [DW-1:0]     rx_head [NUM_EP];
    logic [NUM_EP-1:0] tx_avail;
    logic [NUM_EP-1:0] rx_ready;
    logic              setup_start;
    logic              dir_in;
    logic              dir_out;

    assign dir_in  = (ep_dir_e'(core_dir) == DIR_IN);
    assign dir_out = (ep_dir_e'(core_dir) == DIR_OUT);

    usbep_setup_regs #(.DW(DW), .NBYTES(SETUP_BYTES)) u_setup (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (setup_wr),
        .data   (setup_data),
        .packet (setup_packet),
        .valid  (setup_valid),
        .start  (setup_start)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic ep_flush;
        logic core_sel;

        assign ep_flush = (g == 0) ? setup_start : 1'b0;
        assign core_sel = (core_ep == EPW'(g));

        usbep_tx_lane #(.DW(DW), .DEPTH(DEPTH)) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (ep_flush),
            .cpu_wr     (cpu_wr_en && cpu_wr_ep == EPW'(g)),
            .cpu_data   (cpu_wr_data),
            .cpu_commit (cpu_commit && cpu_wr_ep == EPW'(g)),
            .core_pop   (core_tx_rd && dir_in && core_sel),
            .req        (tx_req[g]),
            .done       (tx_done[g]),
            .err        (tx_err[g]),
            .avail      (tx_avail[g]),
            .head       (tx_head[g])
        );

        usbep_rx_lane #(.DW(DW), .DEPTH(DEPTH)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (ep_flush),
            .core_wr   (core_rx_wr && dir_out && core_sel),
            .core_data (core_rx_data),
            .core_eop  (core_rx_eop && dir_out && core_sel),
            .cpu_rd    (cpu_rd_en && cpu_rd_ep == EPW'(g)),
            .req       (rx_req[g]),
            .ready     (rx_ready[g]),
            .done      (rx_done[g]),
            .err       (rx_err[g]),
            .head      (rx_head[g])
        );
    end

    // Steer the active endpoint onto the core buses and the CPU read bus.
    always_comb begin
        core_tx_data  = tx_head[core_ep];
        core_tx_valid = dir_in && tx_avail[core_ep];
        core_rx_ready = rx_ready[core_ep];
        cpu_rd_data   = rx_head[cpu_rd_ep];
    end
endmodule

// File: rtl/usbep_fifo_bank_chk.sv
// Module: assertion checker bound to the endpoint FIFO bank.
// Assumes: observes ports only.
module usbep_fifo_bank_chk #(
    parameter int NUM_EP = 8,
    parameter int EPW    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_en,
    input logic              core_tx_rd,
    input logic              setup_wr,
    input logic [NUM_EP-1:0] tx_req,
    input logic [NUM_EP-1:0] tx_done,
    input logic [NUM_EP-1:0] tx_err,
    input logic [NUM_EP-1:0] rx_req,
    input logic [NUM_EP-1:0] rx_done,
    input logic [EPW-1:0]    core_ep,
    input logic              core_tx_valid,
    input logic              setup_valid
);
    logic seen   = 1'b0;
    logic prev_n = 1'b1;

    // Track whether the previous edge applied reset.
    always_ff @(posedge clk) begin
        seen   <= 1'b1;
        prev_n <= rst_n;
    end

    // One cycle after a reset edge every flag holds its reset value.
    always_ff @(posedge clk) begin
        if (seen && !prev_n)
            a_r1_reset_state: assert (tx_req == '1 && rx_req == '0 && tx_done == '0
                                      && rx_done == '0 && tx_err == '0 && !setup_valid);
    end

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_err & $past(tx_err)) == $past(tx_err)));

    a_r2_req_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((~tx_req & $past(tx_req)) != '0) |-> $past(cpu_wr_en));

    a_r3_valid_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_valid |-> tx_done[core_ep]);

    a_r4_done_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((~tx_done & $past(tx_done)) != '0) |-> ($past(core_tx_rd) || $past(setup_wr)));

    a_r7_done_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done & ~rx_req) == '0);

    a_r8_valid_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_valid) |-> $past(setup_wr));
endmodule

bind usbep_fifo_bank usbep_fifo_bank_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr_en     (cpu_wr_en),
    .core_tx_rd    (core_tx_rd),
    .setup_wr      (setup_wr),
    .tx_req        (tx_req),
    .tx_done       (tx_done),
    .tx_err        (tx_err),
    .rx_req        (rx_req),
    .rx_done       (rx_done),
    .core_ep       (core_ep),
    .core_tx_valid (core_tx_valid),
    .setup_valid   (setup_valid)
);

// File: tb/tb_usbep_fifo_bank.sv
// Directed bench for the endpoint FIFO bank: one task per scenario.
module tb_usbep_fifo_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 0, cpu_commit = 0, cpu_rd_en = 0;
    logic [2:0]  cpu_wr_ep = 0, cpu_rd_ep = 0, core_ep = 0;
    logic [7:0]  cpu_wr_data = 0, core_rx_data = 0, setup_data = 0;
    logic        core_dir = 0, core_tx_rd = 0, core_rx_wr = 0, core_rx_eop = 0, setup_wr = 0;
    logic [7:0]  cpu_rd_data, core_tx_data;
    logic [7:0]  tx_req, tx_done, tx_err, rx_req, rx_done, rx_err;
    logic        core_tx_valid, core_rx_ready, setup_valid;
    logic [63:0] setup_packet;
    int          checks = 0;
    int          failures = 0;
    bit          ended = 0;

    always #10 clk = ~clk;

    usbep_fifo_bank dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_ep(cpu_wr_ep), .cpu_wr_data(cpu_wr_data),
        .cpu_commit(cpu_commit), .cpu_rd_en(cpu_rd_en), .cpu_rd_ep(cpu_rd_ep),
        .cpu_rd_data(cpu_rd_data), .tx_req(tx_req), .tx_done(tx_done), .tx_err(tx_err),
        .rx_req(rx_req), .rx_done(rx_done), .rx_err(rx_err),
        .core_ep(core_ep), .core_dir(core_dir), .core_tx_rd(core_tx_rd),
        .core_tx_data(core_tx_data), .core_tx_valid(core_tx_valid),
        .core_rx_wr(core_rx_wr), .core_rx_data(core_rx_data), .core_rx_eop(core_rx_eop),
        .core_rx_ready(core_rx_ready), .setup_wr(setup_wr), .setup_data(setup_data),
        .setup_packet(setup_packet), .setup_valid(setup_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Let one rising edge pass; return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [2:0] ep, input logic [7:0] d);
        cpu_wr_en = 1; cpu_wr_ep = ep; cpu_wr_data = d;
        step();
        cpu_wr_en = 0;
    endtask

    task automatic cpu_commit_ep(input logic [2:0] ep);
        cpu_commit = 1; cpu_wr_ep = ep;
        step();
        cpu_commit = 0;
    endtask

    task automatic cpu_read(input logic [2:0] ep, input logic [7:0] exp, input string req);
        cpu_rd_ep = ep;
        #1 check(req, cpu_rd_data, exp);
        cpu_rd_en = 1;
        step();
        cpu_rd_en = 0;
    endtask

    task automatic core_pop(input logic [2:0] ep, input logic [7:0] exp, input string req);
        core_ep = ep; core_dir = 1;
        #1 check(req, core_tx_data, exp);
        core_tx_rd = 1;
        step();
        core_tx_rd = 0;
    endtask

    task automatic core_push(input logic [2:0] ep, input logic [7:0] d, input logic eop);
        core_ep = ep; core_dir = 0; core_rx_wr = 1; core_rx_data = d; core_rx_eop = eop;
        step();
        core_rx_wr = 0; core_rx_eop = 0;
    endtask

    task automatic setup_byte(input logic [7:0] d);
        setup_wr = 1; setup_data = d;
        step();
        setup_wr = 0;
    endtask

    // R1: reset values.
    task automatic t_reset();
        check("R1 tx_req", tx_req, 8'hFF);
        check("R1 rx_req", rx_req, 8'h00);
        check("R1 done", {tx_done, rx_done}, 16'h0);
        check("R1 err", {tx_err, rx_err}, 16'h0);
        check("R1 setup_valid", setup_valid, 1'b0);
    endtask

    // R2/R3/R4/R10: fill, overflow, commit, drain on endpoint 3.
    task automatic t_tx_fill_drain();
        for (int i = 0; i < 8; i++) cpu_write(3, 8'h30 + 8'(i));
        check("R2 tx_req full", tx_req[3], 1'b0);
        check("R2 no err yet", tx_err[3], 1'b0);
        cpu_write(3, 8'hEE);
        check("R2 overflow err", tx_err[3], 1'b1);
        check("R10 other tx_req", tx_req & 8'hF7, 8'hF7);
        core_ep = 3; core_dir = 1; #1;
        check("R3 valid before commit", core_tx_valid, 1'b0);
        core_pop(3, 8'h30, "R3 pop before commit ignored");
        cpu_commit_ep(3);
        check("R3 done set", tx_done[3], 1'b1);
        check("R3 valid after commit", core_tx_valid, 1'b1);
        for (int i = 0; i < 8; i++) core_pop(3, 8'h30 + 8'(i), "R4 tx order");
        check("R4 done cleared", tx_done[3], 1'b0);
        check("R4 valid cleared", core_tx_valid, 1'b0);
        check("R2 req back", tx_req[3], 1'b1);
        check("R2 err sticky", tx_err[3], 1'b1);
    endtask

    // R3: commit of an empty FIFO is ignored.
    task automatic t_tx_empty_commit();
        cpu_commit_ep(5);
        check("R3 empty commit", tx_done[5], 1'b0);
    endtask

    // R4/R11: writes after commit, wrong-direction pop.
    task automatic t_tx_interleave();
        cpu_write(1, 8'h11); cpu_write(1, 8'h12); cpu_write(1, 8'h13);
        cpu_commit_ep(1);
        core_pop(1, 8'h11, "R4 interleave head");
        cpu_write(1, 8'h14);
        core_dir = 0; core_ep = 1; core_tx_rd = 1;
        step();
        core_tx_rd = 0;
        core_pop(1, 8'h12, "R11 dir OUT pop ignored");
        core_pop(1, 8'h13, "R4 interleave");
        check("R4 done while bytes left", tx_done[1], 1'b1);
        core_pop(1, 8'h14, "R4 interleave last");
        check("R4 done cleared interleave", tx_done[1], 1'b0);
    endtask

    // R5/R6/R7: full receive FIFO, separate end-of-packet, drain, underflow.
    task automatic t_rx_full();
        for (int i = 0; i < 8; i++) core_push(2, 8'hA0 + 8'(i), 1'b0);
        core_ep = 2; core_dir = 0; #1;
        check("R5 ready low when full", core_rx_ready, 1'b0);
        check("R5 rx_req", rx_req, 8'h04);
        core_push(2, 8'h55, 1'b0);
        check("R7 no done before eop", rx_done[2], 1'b0);
        core_dir = 1; core_rx_eop = 1;
        step();
        core_rx_eop = 0;
        check("R11 eop with dir IN ignored", rx_done[2], 1'b0);
        core_dir = 0; core_rx_eop = 1;
        step();
        core_rx_eop = 0;
        check("R7 done on eop", rx_done[2], 1'b1);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) check("R7 done before last read", rx_done[2], 1'b1);
            cpu_read(2, 8'hA0 + 8'(i), "R5 rx order, overflow dropped");
        end
        check("R7 done cleared", rx_done[2], 1'b0);
        check("R5 rx_req empty", rx_req[2], 1'b0);
        check("R6 no err yet", rx_err[2], 1'b0);
        cpu_rd_en = 1; cpu_rd_ep = 2;
        step();
        cpu_rd_en = 0;
        check("R6 underflow err", rx_err[2], 1'b1);
        check("R6 still empty", rx_req[2], 1'b0);
    endtask

    // R7: end-of-packet with the last byte; end-of-packet on an empty FIFO.
    task automatic t_rx_eop_edge();
        core_push(6, 8'h61, 1'b0); core_push(6, 8'h62, 1'b0); core_push(6, 8'h63, 1'b1);
        check("R7 done with last byte", rx_done[6], 1'b1);
        cpu_read(6, 8'h61, "R7 read");
        cpu_read(6, 8'h62, "R7 read");
        check("R7 done mid packet", rx_done[6], 1'b1);
        cpu_read(6, 8'h63, "R7 read last");
        check("R7 done cleared after last", rx_done[6], 1'b0);
        core_ep = 4; core_dir = 0; core_rx_eop = 1;
        step();
        core_rx_eop = 0;
        check("R7 eop on empty", rx_done[4], 1'b0);
    endtask

    // R8/R9/R10: SETUP capture and endpoint 0 flush.
    task automatic t_setup();
        for (int i = 0; i < 8; i++) cpu_write(0, 8'h0A);
        cpu_commit_ep(0);
        core_push(0, 8'h0B, 1'b1);
        core_push(7, 8'h71, 1'b0);
        check("R9 ep0 loaded", {tx_req[0], tx_done[0], rx_req[0], rx_done[0]}, 4'b0111);
        setup_byte(8'h80);
        check("R9 ep0 flushed", {tx_req[0], tx_done[0], rx_req[0], rx_done[0]}, 4'b1000);
        check("R9 other ep kept", rx_req[7], 1'b1);
        for (int i = 1; i < 8; i++) begin
            check("R8 valid not early", setup_valid, 1'b0);
            setup_byte(8'h80 + 8'(i));
        end
        check("R8 valid", setup_valid, 1'b1);
        check("R8 packet", setup_packet, 64'h8786858483828180);
        check("R8 no fifo write", rx_req[0], 1'b0);
        setup_byte(8'h90);
        check("R9 valid cleared on new stage", setup_valid, 1'b0);
        check("R9 byte0 overwritten", setup_packet[7:0], 8'h90);
        cpu_read(7, 8'h71, "R10 ep7 data intact");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_tx_fill_drain();
        t_tx_empty_commit();
        t_tx_interleave();
        t_rx_full();
        t_rx_eop_edge();
        t_setup();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule